// File: doc/BRIEF.md
# Highway and Farm-Road Light Controller

This block sequences the lamps at a crossing where a busy highway meets a rarely used farm road. The highway keeps a green lamp by default. A sensor on the farm road reports a waiting car. When the highway has been green for at least the long interval and a car is waiting, the highway goes through yellow to red and the farm road turns green. The farm road keeps its green only while a car is still sensed, and never for longer than the long interval. It then goes through yellow back to red, and the highway returns to green.

An internal interval counter measures every phase. It restarts on each change of phase. A short bound times the yellow lamps and a long bound times the green lamps. Both bounds and the counter width are parameters. A parameter also chooses whether the lamp outputs come straight from the phase register through logic or from their own flops. Either choice gives the same cycle timing.

Top module: `crossroad_light_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the highway shows green and the farm road shows red.
- R2: Highway green lasts at least LONG_CYC+1 cycles. It ends only at the first clock edge where `car_waiting` is high and the phase has already lasted LONG_CYC+1 cycles. A car that is sensed earlier does not end the phase.
- R3: Highway yellow, with farm red, lasts exactly SHORT_CYC+1 cycles and is followed by farm green with highway red.
- R4: Farm green ends at the first edge where `car_waiting` is low, or after LONG_CYC+1 cycles, whichever comes first. It is followed by farm yellow with highway red.
- R5: Farm yellow lasts exactly SHORT_CYC+1 cycles and is followed by highway green.
- R6: Lamp vectors use bit 0 for green, bit 1 for yellow and bit 2 for red. Each road has exactly one bit set in every cycle.
- R7: At least one road shows red in every cycle, so both roads never show green or yellow together.
- R8: The interval count restarts at every phase change and holds at its long bound. A highway green that has already run past LONG_CYC+1 cycles therefore ends at the first edge where a car is sensed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_waiting | input | 1 | High while a car is detected on the farm road |
| hwy_lamp | output | 3 | Highway lamps: bit 0 green, bit 1 yellow, bit 2 red |
| farm_lamp | output | 3 | Farm-road lamps: bit 0 green, bit 1 yellow, bit 2 red |

## Verification
The controller responds to a change of `car_waiting` at the next rising edge. The lamps for the new phase are then valid one edge after the sample, whichever output variant is built. A phase that begins at edge k reaches its short bound at edge k+SHORT_CYC and its long bound at edge k+LONG_CYC. A timed exit therefore shows on the lamps SHORT_CYC+1 or LONG_CYC+1 cycles after entry. The bench drives the sensor after each falling edge. It steps a reference phase-and-count model once per rising edge and compares the lamps at the following falling edge. The directed runs count the cycles each lamp pattern lasts and compare that count with these sums.

// File: rtl/xing_pkg.sv
package xing_pkg;

   typedef enum logic [1:0] {
      PH_HWY_GO    = 2'd0,
      PH_HWY_WARN  = 2'd1,
      PH_FARM_GO   = 2'd2,
      PH_FARM_WARN = 2'd3
   } phase_t;

   localparam int LAMP_W     = 3;
   localparam int LAMP_GREEN = 0;
   localparam int LAMP_AMBER = 1;
   localparam int LAMP_RED   = 2;

   typedef struct packed {
      logic [LAMP_W-1:0] hwy;
      logic [LAMP_W-1:0] farm;
   } lamps_t;

   function automatic logic [LAMP_W-1:0] one_lamp(int idx);
      logic [LAMP_W-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

   function automatic lamps_t lamps_of(phase_t p);
      lamps_t l;
      case (p)
         PH_HWY_GO:    begin l.hwy = one_lamp(LAMP_GREEN); l.farm = one_lamp(LAMP_RED);   end
         PH_HWY_WARN:  begin l.hwy = one_lamp(LAMP_AMBER); l.farm = one_lamp(LAMP_RED);   end
         PH_FARM_GO:   begin l.hwy = one_lamp(LAMP_RED);   l.farm = one_lamp(LAMP_GREEN); end
         default:      begin l.hwy = one_lamp(LAMP_RED);   l.farm = one_lamp(LAMP_AMBER); end
      endcase
      return l;
   endfunction

endpackage

// File: rtl/xing_interval_timer.sv
module xing_interval_timer #(
   parameter int CNT_W     = 8,
   parameter int SHORT_CYC = 3,
   parameter int LONG_CYC  = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic short_done,
   output logic long_done
);

   localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
   localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (restart)         cnt_q <= '0;
      else if (cnt_q != LONG_V) cnt_q <= cnt_q + 1'b1;
   end

   assign short_done = (cnt_q >= SHORT_V);
   assign long_done  = (cnt_q >= LONG_V);

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0)); // R8
   AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (long_done && !restart) |=> long_done && $stable(cnt_q)); // R8
   AST_SHORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      long_done |-> short_done); // R8

endmodule

// File: rtl/xing_phase_fsm.sv
module xing_phase_fsm
   import xing_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   car,
   input  logic   short_done,
   input  logic   long_done,
   output logic   restart,
   output phase_t phase_q,
   output phase_t phase_d
);

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_HWY_GO:    if (car && long_done)  phase_d = PH_HWY_WARN;
         PH_HWY_WARN:  if (short_done)        phase_d = PH_FARM_GO;
         PH_FARM_GO:   if (!car || long_done) phase_d = PH_FARM_WARN;
         PH_FARM_WARN: if (short_done)        phase_d = PH_HWY_GO;
         default:                             phase_d = PH_HWY_GO;
      endcase
   end

   assign restart = (phase_d != phase_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_HWY_GO;
      else        phase_q <= phase_d;
   end

   AST_HWY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HWY_GO && !(car && long_done)) |=> phase_q == PH_HWY_GO); // R2
   AST_HWY_WARN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HWY_WARN && !short_done) |=> phase_q == PH_HWY_WARN); // R3
   AST_FARM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FARM_GO && !car) |=> phase_q == PH_FARM_WARN); // R4
   AST_FARM_WARN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FARM_WARN) |=> (phase_q == PH_FARM_WARN || phase_q == PH_HWY_GO)); // R5

endmodule

// File: rtl/xing_lamp_drive.sv
module xing_lamp_drive
   import xing_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            phase_q,
   input  phase_t            phase_d,
   output logic [LAMP_W-1:0] hwy_lamp,
   output logic [LAMP_W-1:0] farm_lamp
);

   lamps_t lamps;

   generate
      if (OUT_REG) begin : g_flopped
         lamps_t lamps_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lamps_q <= lamps_of(PH_HWY_GO);
            else        lamps_q <= lamps_of(phase_d);
         end
         assign lamps = lamps_q;
      end else begin : g_direct
         assign lamps = lamps_of(phase_q);
      end
   endgenerate

   assign hwy_lamp  = lamps.hwy;
   assign farm_lamp = lamps.farm;

   AST_ONE_LAMP_EACH: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(hwy_lamp) == 1) && ($countones(farm_lamp) == 1)); // R6
   AST_ONE_ROAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
      hwy_lamp[LAMP_RED] || farm_lamp[LAMP_RED]); // R7

endmodule

// File: rtl/crossroad_light_ctrl.sv
module crossroad_light_ctrl
   import xing_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int SHORT_CYC = 3,
   parameter int LONG_CYC  = 10,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              car_waiting,
   output logic [LAMP_W-1:0] hwy_lamp,
   output logic [LAMP_W-1:0] farm_lamp
);

   localparam longint CNT_MAX = (64'd1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("crossroad_light_ctrl: CNT_W out of range");
      end
      if (SHORT_CYC < 1) begin : g_bad_short
         $error("crossroad_light_ctrl: SHORT_CYC must be at least 1");
      end
      if (LONG_CYC <= SHORT_CYC) begin : g_bad_order
         $error("crossroad_light_ctrl: LONG_CYC must exceed SHORT_CYC");
      end
      if (longint'(LONG_CYC) > CNT_MAX) begin : g_bad_fit
         $error("crossroad_light_ctrl: LONG_CYC does not fit in CNT_W bits");
      end
   endgenerate

   logic   restart;
   logic   short_done;
   logic   long_done;
   phase_t phase_q;
   phase_t phase_d;

   xing_interval_timer #(
      .CNT_W    (CNT_W),
      .SHORT_CYC(SHORT_CYC),
      .LONG_CYC (LONG_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .short_done(short_done),
      .long_done (long_done)
   );

   xing_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .car       (car_waiting),
      .short_done(short_done),
      .long_done (long_done),
      .restart   (restart),
      .phase_q   (phase_q),
      .phase_d   (phase_d)
   );

   xing_lamp_drive #(
      .OUT_REG(OUT_REG)
   ) u_lamps (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_q  (phase_q),
      .phase_d  (phase_d),
      .hwy_lamp (hwy_lamp),
      .farm_lamp(farm_lamp)
   );

endmodule

// File: tb/crossroad_light_ctrl_test.sv
`timescale 1ns/1ps
module crossroad_light_ctrl_test;

   localparam int SHORT_CYC = 3;
   localparam int LONG_CYC  = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       car_waiting = 1'b0;
   logic [2:0] hwy_lamp;
   logic [2:0] farm_lamp;

   int vectors = 0;
   int errors  = 0;
   int m_ph    = 0;
   int m_cnt   = 0;

   // reference lamp values: bit0 green, bit1 yellow, bit2 red
   localparam logic [2:0] GRN = 3'b001, YEL = 3'b010, RED = 3'b100;

   crossroad_light_ctrl #(
      .CNT_W(8), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .OUT_REG(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .car_waiting(car_waiting),
      .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp)
   );

   always #10 clk = ~clk;

   function automatic logic [5:0] exp_lamps(int ph);
      case (ph)
         0: return {GRN, RED};
         1: return {YEL, RED};
         2: return {RED, GRN};
         default: return {RED, YEL};
      endcase
   endfunction

   function automatic string tag_of(int ph);
      case (ph)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp_v);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   // one rising edge with the sensor at c; model steps, lamps compared after
   task automatic tick(input logic c);
      int nph;
      bit leave;
      car_waiting = c;
      nph = m_ph;
      case (m_ph)
         0: leave = c && (m_cnt >= LONG_CYC);
         1: leave = (m_cnt >= SHORT_CYC);
         2: leave = !c || (m_cnt >= LONG_CYC);
         default: leave = (m_cnt >= SHORT_CYC);
      endcase
      if (leave) begin
         nph = (m_ph + 1) % 4;
         m_cnt = 0;
      end else if (m_cnt < LONG_CYC) begin
         m_cnt++;
      end
      m_ph = nph;
      @(posedge clk);
      @(negedge clk);
      check({hwy_lamp, farm_lamp} == exp_lamps(m_ph), tag_of(m_ph),
            int'({hwy_lamp, farm_lamp}), int'(exp_lamps(m_ph)));
      check(($countones(hwy_lamp) == 1) && ($countones(farm_lamp) == 1), "R6",
            int'({hwy_lamp, farm_lamp}), 0);
      check(hwy_lamp[2] || farm_lamp[2], "R7", int'({hwy_lamp, farm_lamp}), 0);
   endtask

   // count cycles the present lamp pattern lasts with the sensor held at c
   task automatic dwell(input logic c, output int n);
      logic [5:0] pat;
      pat = {hwy_lamp, farm_lamp};
      n = 0;
      while ({hwy_lamp, farm_lamp} == pat && n < 1000) begin
         n++;
         tick(c);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check({hwy_lamp, farm_lamp} == {GRN, RED}, "R1", int'({hwy_lamp, farm_lamp}), int'({GRN, RED}));
      rst_n = 1'b1;
      @(negedge clk);
      m_ph = 0; m_cnt = 1;  // one edge already taken with no car
      check({hwy_lamp, farm_lamp} == {GRN, RED}, "R1", int'({hwy_lamp, farm_lamp}), int'({GRN, RED}));

      // R2: no car for a long time keeps highway green
      repeat (2 * LONG_CYC) tick(1'b0);
      check(hwy_lamp == GRN, "R2", int'(hwy_lamp), int'(GRN));
      // R8: count saturated, so the first sensed car ends highway green
      tick(1'b1);
      check(hwy_lamp == YEL, "R8", int'(hwy_lamp), int'(YEL));
      dwell(1'b1, n);
      check(n == SHORT_CYC + 1, "R3", n, SHORT_CYC + 1);
      check(farm_lamp == GRN, "R3", int'(farm_lamp), int'(GRN));
      dwell(1'b1, n);
      check(n == LONG_CYC + 1, "R4", n, LONG_CYC + 1);
      dwell(1'b1, n);
      check(n == SHORT_CYC + 1, "R5", n, SHORT_CYC + 1);
      check(hwy_lamp == GRN, "R5", int'(hwy_lamp), int'(GRN));
      // R2: car waiting from entry still gets the full minimum green
      dwell(1'b1, n);
      check(n == LONG_CYC + 1, "R2", n, LONG_CYC + 1);
      dwell(1'b1, n);
      check(n == SHORT_CYC + 1, "R3", n, SHORT_CYC + 1);
      // R4: farm green releases on the first edge without a car
      tick(1'b1);
      tick(1'b0);
      check(farm_lamp == YEL, "R4", int'(farm_lamp), int'(YEL));
      dwell(1'b0, n);
      check(n == SHORT_CYC + 1, "R5", n, SHORT_CYC + 1);

      // constrained random sensor traffic, biased toward long runs
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 8) tick(~car_waiting);
         else       tick(car_waiting);
      end

      // mid-run reset returns to highway green (R1)
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check({hwy_lamp, farm_lamp} == {GRN, RED}, "R1", int'({hwy_lamp, farm_lamp}), int'({GRN, RED}));
      finish_run();
   end

endmodule